// File: doc/BRIEF.md
# Correlating Two-Bit Branch Predictor

This block guesses the direction of conditional branches for an instruction fetch unit. Alongside a table row picked by low instruction-address bits, it uses a short global record of how the most recent branches actually went. Each row holds one small saturating counter for every possible recent-outcome pattern. The current pattern picks which counter in the row answers the lookup.

A taken answer tells fetch to continue at the branch destination. A not-taken answer tells fetch to continue at the next sequential instruction. The lookup is purely combinational: an address goes in and a direction comes out in the same cycle. The pattern used is also returned, so the pipeline can carry it with the branch.

When the branch resolves, the pipeline sends back three things: the branch address, the pattern that was used at lookup, and the real outcome. The block then steps the chosen counter and shifts the real outcome into the global pattern. A restore input lets the pipeline overwrite the pattern after a flush. A parameter selects between two counter types: two-bit counters with hysteresis, or one-bit last-outcome counters.

Top module: `corr_bpred`

## Requirements
- R1: After reset every counter predicts not taken (two-bit counters hold 1, weakly not taken; one-bit counters hold 0), and the global pattern is 3'b000.
- R2: A lookup selects row lk_pc[5:2] and the counter picked by the current global pattern within that row. lk_taken and lk_hist follow in the same cycle with no clock edge.
- R3: In two-bit mode, the prediction is taken exactly when the counter is 2 or 3. An update moves the counter up one step on a taken outcome and down one step otherwise, saturating at 3 and at 0.
- R4: In two-bit mode, a counter at 3 that sees a single not-taken outcome still predicts taken.
- R5: An update changes the counter at row up_pc[5:2] selected by up_hist, not by the current global pattern.
- R6: Each update shifts up_taken into bit 0 of the global pattern; older outcomes move toward bit 2 and bit 2 is dropped.
- R7: A restore loads rs_hist into the global pattern on the next edge. When a restore and an update fall in the same cycle, the restore value wins, and the counter update still happens.
- R8: A lookup in the same cycle as an update sees the counter and pattern from before that update.
- R9: In one-bit mode (CTR_BITS=1), the prediction for a row and pattern equals the last outcome written under that row and pattern.
- R10: Address bits outside [5:2] have no effect on which counter is read or written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | 32 | Address of the branch being looked up |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| lk_hist | output | 3 | Global pattern used for this lookup |
| up_valid | input | 1 | A resolved branch is being reported |
| up_pc | input | 32 | Address of the resolved branch |
| up_hist | input | 3 | Pattern that was used when that branch was looked up |
| up_taken | input | 1 | Actual outcome, 1 = taken |
| rs_valid | input | 1 | Overwrite the global pattern |
| rs_hist | input | 3 | Value loaded by a restore |

## Verification
Two functions can fall in the same cycle: a lookup and an update, and a restore and an update. For the first, the bench holds a lookup on the same counter and pattern that an update is writing. It judges the result against the pre-update counter of its own model and the unshifted pattern. For the second, it raises restore and update together and then checks two things: that the pattern equals the restore value, and that the written counter still moved as one update should.

// File: rtl/bp_pkg.sv
package bp_pkg;
  localparam int unsigned CW = 8;

  // one saturating step toward taken (tk=1) or not taken (tk=0)
  function automatic logic [CW-1:0] ctr_step(input logic [CW-1:0] c,
                                             input logic tk,
                                             input logic [CW-1:0] maxv);
    logic [CW-1:0] r;
    if (tk) r = (c == maxv) ? c : c + 1'b1;
    else    r = (c == '0)   ? c : c - 1'b1;
    return r;
  endfunction

  // top bit of an n-bit counter gives the direction
  function automatic logic ctr_dir(input logic [CW-1:0] c, input int unsigned bits);
    return c[bits-1];
  endfunction
endpackage

// File: rtl/bp_hist.sv
module bp_hist #(
  parameter int unsigned HB = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sh_en,
  input  logic          sh_bit,
  input  logic          ld_en,
  input  logic [HB-1:0] ld_val,
  output logic [HB-1:0] hist
);
  logic [HB-1:0] shifted;
  assign shifted = {hist[HB-2:0], sh_bit};

  always_ff @(posedge clk) begin
    if (!rst_n)     hist <= '0;
    else if (ld_en) hist <= ld_val;
    else if (sh_en) hist <= shifted;
  end

  // R6
  hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_en && !ld_en) |=> (hist[0] == $past(sh_bit) && hist[HB-1:1] == $past(hist[HB-2:0])));

  // R7
  hist_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> (hist == $past(ld_val)));

  // R6
  hist_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sh_en && !ld_en) |=> $stable(hist));
endmodule

// File: rtl/bp_table.sv
module bp_table #(
  parameter int unsigned IW = 7,
  parameter int unsigned CB = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] rd_idx,
  output logic [CB-1:0] rd_ctr,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic          wr_tk
);
  import bp_pkg::*;
  localparam int unsigned DEPTH = 1 << IW;
  localparam logic [CB-1:0] RST_V = CB'((1 << (CB - 1)) - 1);
  localparam logic [CW-1:0] MAXV = CW'((1 << CB) - 1);

  logic [CB-1:0] cells [DEPTH];
  logic [CW-1:0] wr_old, wr_new;

  assign rd_ctr = cells[rd_idx];
  assign wr_old = CW'(cells[wr_idx]);
  assign wr_new = ctr_step(wr_old, wr_tk, MAXV);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= RST_V;
    end else if (wr_en) begin
      cells[wr_idx] <= wr_new[CB-1:0];
    end
  end

  // record of the last write, kept for the checks below
  logic          last_wr, last_tk;
  logic [IW-1:0] last_idx;
  logic [CW-1:0] last_old, now_val;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_wr <= 1'b0; last_tk <= 1'b0; last_idx <= '0; last_old <= '0;
    end else begin
      last_wr <= wr_en; last_tk <= wr_tk; last_idx <= wr_idx; last_old <= wr_old;
    end
  end
  assign now_val = CW'(cells[last_idx]);

  // R3
  step_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_wr |-> (last_tk ? (now_val >= last_old) : (now_val <= last_old)));

  // R3
  step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_wr |-> (now_val == last_old || now_val == last_old + 1 || now_val + 1 == last_old));

  // R3
  sat_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_wr && last_tk && last_old == MAXV) |-> (now_val == MAXV));

  // R3
  sat_bot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_wr && !last_tk && last_old == '0) |-> (now_val == '0));
endmodule

// File: rtl/corr_bpred.sv
module corr_bpred #(
  parameter int unsigned PC_W     = 32,
  parameter int unsigned PC_LSB   = 2,
  parameter int unsigned ROW_BITS = 4,
  parameter int unsigned HIST_W   = 3,
  parameter int unsigned CTR_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   lk_pc,
  output logic              lk_taken,
  output logic [HIST_W-1:0] lk_hist,
  input  logic              up_valid,
  input  logic [PC_W-1:0]   up_pc,
  input  logic [HIST_W-1:0] up_hist,
  input  logic              up_taken,
  input  logic              rs_valid,
  input  logic [HIST_W-1:0] rs_hist
);
  import bp_pkg::*;
  localparam int unsigned IW  = ROW_BITS + HIST_W;
  localparam int unsigned TOP = PC_LSB + ROW_BITS;

  logic [HIST_W-1:0] g_hist;
  logic [IW-1:0]     rd_idx, wr_idx;
  logic [CTR_BITS-1:0] rd_ctr;

  bp_hist #(.HB(HIST_W)) u_hist (
    .clk(clk), .rst_n(rst_n),
    .sh_en(up_valid), .sh_bit(up_taken),
    .ld_en(rs_valid), .ld_val(rs_hist),
    .hist(g_hist)
  );

  assign rd_idx = {lk_pc[TOP-1:PC_LSB], g_hist};
  assign wr_idx = {up_pc[TOP-1:PC_LSB], up_hist};

  bp_table #(.IW(IW), .CB(CTR_BITS)) u_tab (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(rd_idx), .rd_ctr(rd_ctr),
    .wr_en(up_valid), .wr_idx(wr_idx), .wr_tk(up_taken)
  );

  assign lk_taken = ctr_dir(CW'(rd_ctr), CTR_BITS);
  assign lk_hist  = g_hist;

  // address bits that play no part in indexing
  logic unused_pc_bits;
  assign unused_pc_bits = ^{lk_pc[PC_W-1:TOP], lk_pc[PC_LSB-1:0],
                            up_pc[PC_W-1:TOP], up_pc[PC_LSB-1:0]};

  // R2
  pred_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(lk_pc) && !$past(up_valid) && !$past(rs_valid)) |-> $stable(lk_taken));

  // R2
  hist_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(up_valid) && !$past(rs_valid)) |-> $stable(lk_hist));
endmodule

// File: tb/sim_corr_bpred.sv
module sim_corr_bpred;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] lk_pc = '0, up_pc = '0;
  logic [2:0]  up_hist = '0, rs_hist = '0;
  logic up_valid = 1'b0, up_taken = 1'b0, rs_valid = 1'b0;
  logic lk_t2, lk_t1;
  logic [2:0] lk_h2, lk_h1;

  always #10 clk = ~clk;

  corr_bpred #(.CTR_BITS(2)) u0 (.clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_t2),
    .lk_hist(lk_h2), .up_valid(up_valid), .up_pc(up_pc), .up_hist(up_hist),
    .up_taken(up_taken), .rs_valid(rs_valid), .rs_hist(rs_hist));
  corr_bpred #(.CTR_BITS(1)) u1 (.clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_t1),
    .lk_hist(lk_h1), .up_valid(up_valid), .up_pc(up_pc), .up_hist(up_hist),
    .up_taken(up_taken), .rs_valid(rs_valid), .rs_hist(rs_hist));

  int n_chk = 0, n_bad = 0;
  int m2 [128];
  int m1 [128];
  logic [2:0] mh;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int midx(input logic [31:0] pc, input logic [2:0] h);
    return int'(pc[5:2]) * 8 + int'(h);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 128; i++) begin m2[i] = 1; m1[i] = 0; end
    mh = 3'b000;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; up_valid = 1'b0; rs_valid = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  task automatic do_restore(input logic [2:0] h);
    @(negedge clk);
    rs_valid = 1'b1; rs_hist = h;
    @(negedge clk);
    rs_valid = 1'b0;
    mh = h;
  endtask

  task automatic model_update(input logic [31:0] pc, input logic [2:0] h, input logic t);
    int k;
    k = midx(pc, h);
    if (t) m2[k] = (m2[k] >= 3) ? 3 : m2[k] + 1;
    else   m2[k] = (m2[k] <= 0) ? 0 : m2[k] - 1;
    m1[k] = t ? 1 : 0;
    mh = {mh[1:0], t};
  endtask

  task automatic do_update(input logic [31:0] pc, input logic [2:0] h, input logic t);
    @(negedge clk);
    up_valid = 1'b1; up_pc = pc; up_hist = h; up_taken = t;
    @(negedge clk);
    up_valid = 1'b0;
    model_update(pc, h, t);
  endtask

  // restore a pattern, look up pc, compare both instances
  task automatic look(input string tag, input logic [31:0] pc, input logic [2:0] h,
                      input int e2, input int e1);
    do_restore(h);
    lk_pc = pc;
    #1;
    chk({tag, " two-bit"}, int'(lk_t2), e2);
    chk({tag, " one-bit"}, int'(lk_t1), e1);
  endtask

  // vector: {row[3:0], hist[2:0], taken}
  localparam int NV = 16;
  localparam logic [7:0] VEC [NV] = '{
    {4'd3, 3'd5, 1'b1}, {4'd3, 3'd5, 1'b1}, {4'd3, 3'd5, 1'b0}, {4'd3, 3'd5, 1'b0},
    {4'd0, 3'd0, 1'b1}, {4'd15, 3'd7, 1'b1}, {4'd15, 3'd7, 1'b1}, {4'd15, 3'd7, 1'b1},
    {4'd15, 3'd7, 1'b0}, {4'd8, 3'd2, 1'b0}, {4'd8, 3'd2, 1'b1}, {4'd8, 3'd2, 1'b1},
    {4'd3, 3'd4, 1'b1}, {4'd3, 3'd5, 1'b1}, {4'd12, 3'd1, 1'b0}, {4'd0, 3'd0, 1'b1}
  };

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual 0 expected 1 (run did not end)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1: reset state at a spread of addresses
    #1;
    chk("R1 pattern after reset", int'(lk_h2), 0);
    for (int r = 0; r < 16; r += 5) begin
      lk_pc = 32'(r) << 2;
      #1;
      chk("R1 two-bit predicts not taken", int'(lk_t2), 0);
      chk("R1 one-bit predicts not taken", int'(lk_t1), 0);
    end

    // table walk: R2 lookup, R8 same-cycle view, R6 shift, R3/R9 counters
    for (int v = 0; v < NV; v++) begin
      logic [31:0] pc;
      logic [2:0] h;
      logic t;
      int k;
      pc = {24'hA5_0000 + 24'(v), VEC[v][7:4], 2'b01} ;
      h = VEC[v][3:1];
      t = VEC[v][0];
      k = midx(pc, h);
      look("R2 lookup", pc, h, (m2[k] >= 2) ? 1 : 0, m1[k]);
      chk("R2 pattern out", int'(lk_h2), int'(h));
      @(negedge clk);
      up_valid = 1'b1; up_pc = pc; up_hist = h; up_taken = t;
      #1;
      chk("R8 same-cycle two-bit", int'(lk_t2), (m2[k] >= 2) ? 1 : 0);
      chk("R8 same-cycle one-bit", int'(lk_t1), m1[k]);
      chk("R8 same-cycle pattern", int'(lk_h2), int'(h));
      @(negedge clk);
      up_valid = 1'b0;
      model_update(pc, h, t);
      #1;
      chk("R6 shifted pattern", int'(lk_h2), int'({h[1:0], t}));
      chk("R6 shifted pattern one-bit", int'(lk_h1), int'(mh));
    end

    // R4 and R9: hysteresis versus last-outcome
    do_reset();
    repeat (3) do_update(32'h0000_0014, 3'd3, 1'b1);
    do_update(32'h0000_0014, 3'd3, 1'b0);
    look("R4 strong taken survives one miss", 32'h0000_0014, 3'd3, 1, 0);
    look("R9 one-bit follows last outcome", 32'h0000_0014, 3'd3, m2[midx(32'h14, 3'd3)] >= 2 ? 1 : 0, 0);
    do_update(32'h0000_0014, 3'd3, 1'b0);
    look("R4 second miss flips", 32'h0000_0014, 3'd3, 0, 0);

    // R3: saturation at the bottom, then climb
    repeat (4) do_update(32'h0000_001C, 3'd0, 1'b0);
    do_update(32'h0000_001C, 3'd0, 1'b1);
    look("R3 one step up from floor", 32'h0000_001C, 3'd0, 0, 1);
    do_update(32'h0000_001C, 3'd0, 1'b1);
    look("R3 second step reaches taken", 32'h0000_001C, 3'd0, 1, 1);
    repeat (5) do_update(32'h0000_001C, 3'd0, 1'b1);
    do_update(32'h0000_001C, 3'd0, 1'b0);
    look("R3 ceiling holds after one miss", 32'h0000_001C, 3'd0, 1, 0);

    // R5: update follows up_hist, not the live pattern
    do_restore(3'd0);
    do_update(32'h0000_0008, 3'd6, 1'b1);
    do_update(32'h0000_0008, 3'd6, 1'b1);
    look("R5 written under passed pattern", 32'h0000_0008, 3'd6, 1, 1);
    look("R5 live pattern entry untouched", 32'h0000_0008, 3'd0, 0, 0);

    // R7: restore and update together
    @(negedge clk);
    rs_valid = 1'b1; rs_hist = 3'b101;
    up_valid = 1'b1; up_pc = 32'h0000_0024; up_hist = 3'd2; up_taken = 1'b1;
    @(negedge clk);
    rs_valid = 1'b0; up_valid = 1'b0;
    model_update(32'h0000_0024, 3'd2, 1'b1);
    mh = 3'b101;
    #1;
    chk("R7 restore wins over shift", int'(lk_h2), 5);
    look("R7 counter still written", 32'h0000_0024, 3'd2, 1, 1);

    // R10: only bits [5:2] matter
    look("R10 high and low bits ignored", 32'hFFFF_FFE7, 3'd2, 1, 1);
    do_update(32'h8000_0026, 3'd2, 1'b0);
    do_update(32'h4000_0065, 3'd2, 1'b0);
    look("R10 aliased writes hit one counter", 32'h0000_0024, 3'd2, 0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule